// File: doc/BRIEF.md
# Fractional-N Modulus Accumulator

This block decides, once per comparison cycle of a frequency synthesiser, whether the main loop divider should count one extra time. The result is an average division ratio of N plus a fraction. On every comparison strobe a 3-bit numerator is added to a small accumulator. The accumulator's modulus, which is also the fraction's denominator, is either 5 or 8. When the sum reaches the modulus, the modulus is subtracted and a one-clock carry request goes to the divider, which stretches a single prescaler cycle.

Over one full period of modulus strobes, exactly numerator carries come out, whatever the accumulator's starting value. The carries are spaced through the period rather than grouped together, which keeps the phase error small. The accumulator is held at zero in three cases: while the block is disabled, while the numerator is zero, and for one clock after the modulus select changes. Because of this, every restart begins at a known point of the pattern.

Top module: `frac_acc`

## Requirements
- R1: After reset, `carry` is 0 and the accumulator is zero. With modulus 8 and `num` = 3, the first carry comes on the third strobe.
- R2: `carry` is a registered pulse. It goes high only in the clock that follows a clock with `strobe` = 1 (while enabled), and it is 0 in any clock that follows a clock with `strobe` = 0.
- R3: With `mod8` = 1 (modulus 8), every 8 consecutive strobes produce exactly `num` carries, for `num` from 1 to 7.
- R4: With `mod8` = 0 (modulus 5), every 5 consecutive strobes produce exactly `num` carries, for `num` from 1 to 4. The accumulator always stays below the modulus in force.
- R5: With modulus 5, a `num` of 5, 6 or 7 is treated as 4, giving 4 carries in every 5 strobes.
- R6: While `en` = 0, `carry` stays 0 and the accumulator is cleared. After `en` returns to 1, the pattern starts again from zero.
- R7: While `num` = 0, `carry` stays 0 and the accumulator is cleared.
- R8: Carries are spread through the period. Starting from zero with modulus 8 and `num` = 3, they fall on strobes 3, 6 and 8. Starting from zero with modulus 5 and `num` = 2, they fall on strobes 3 and 5.
- R9: A change of `mod8` clears the accumulator and suppresses `carry` for that clock, so the new modulus starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables fractional operation |
| strobe | input | 1 | One-clock comparison-cycle pulse |
| num | input | 3 | Fraction numerator |
| mod8 | input | 1 | 1 selects modulus 8, 0 selects modulus 5 |
| carry | output | 1 | One-clock request to add one count to the divider |

## Verification
The hardest conditions to reach are ones where the accumulator holds a leftover, non-zero value and some event must throw it away: disabling the block, a numerator of zero, or a switch of modulus. Each test first runs two strobes with modulus 8 and a numerator of 3, which leaves the accumulator at 6. It then applies the clearing event and checks the exact strobe positions of the next carries. A stale value of 6 would produce a carry on the very first strobe, which a cleared accumulator never does.

// File: rtl/frac_acc.sv
module frac_acc #(
  parameter int NUM_W  = 3,
  parameter int MOD_LO = 5,
  parameter int MOD_HI = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             strobe,
  input  logic [NUM_W-1:0] num,
  input  logic             mod8,
  output logic             carry
);
  localparam int ACC_W = $clog2(MOD_HI);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic             mod_q;

  wire [SUM_W-1:0] modulus = mod8 ? SUM_W'(MOD_HI) : SUM_W'(MOD_LO);
  wire [NUM_W-1:0] num_eff = (!mod8 && num >= NUM_W'(MOD_LO)) ? NUM_W'(MOD_LO - 1) : num;
  wire [SUM_W-1:0] sum     = SUM_W'(acc_q) + SUM_W'(num_eff);
  wire             wrap    = sum >= modulus;
  wire [SUM_W-1:0] nxt     = wrap ? sum - modulus : sum;
  wire             idle    = !en || (num == '0) || (mod8 != mod_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      carry <= 1'b0;
      mod_q <= 1'b0;
    end else begin
      mod_q <= mod8;
      if (idle) begin
        acc_q <= '0;
        carry <= 1'b0;
      end else if (strobe) begin
        acc_q <= nxt[ACC_W-1:0];
        carry <= wrap;
      end else begin
        carry <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frac_acc_chk.sv
module frac_acc_chk #(
  parameter int NUM_W  = 3,
  parameter int MOD_LO = 5,
  parameter int MOD_HI = 8,
  parameter int ACC_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             strobe,
  input logic [NUM_W-1:0] num,
  input logic             mod8,
  input logic             carry,
  input logic [ACC_W-1:0] acc
);
  AST_CARRY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> $past(strobe && en)); // R2
  AST_NO_STROBE_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !carry); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!carry && acc == '0)); // R6
  AST_ZERO_NUM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (num == '0) |=> !carry); // R7
  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, acc} < ($past(mod8) ? (ACC_W+1)'(MOD_HI) : (ACC_W+1)'(MOD_LO))); // R4
  AST_MODE_SWITCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mod8 != $past(mod8)) |=> (!carry && acc == '0)); // R9
endmodule

bind frac_acc frac_acc_chk #(.NUM_W(NUM_W), .MOD_LO(MOD_LO), .MOD_HI(MOD_HI), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .strobe(strobe), .num(num),
  .mod8(mod8), .carry(carry), .acc(acc_q)
);

// File: tb/sim_frac_acc.sv
module sim_frac_acc;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic strobe = 1'b0;
  logic [2:0] num = 3'd0;
  logic mod8 = 1'b1;
  logic carry;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  frac_acc u0 (.clk(clk), .rst_n(rst_n), .en(en), .strobe(strobe),
               .num(num), .mod8(mod8), .carry(carry));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one strobe, returns carry seen one clock later; also checks the gap clock
  task automatic pulse(output bit c);
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    c = carry;
    @(negedge clk);
    chk(carry == 1'b0, "R2 gap", int'(carry), 0);
  endtask

  task automatic clear_acc;
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic count_run(input int n, output int cnt);
    bit c;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      pulse(c);
      cnt += int'(c);
    end
  endtask

  task automatic pattern(input string req, input int n, input bit [7:0] exp);
    bit c;
    for (int i = 0; i < n; i++) begin
      pulse(c);
      chk(c == exp[i], req, int'(c), int'(exp[i]));
    end
  endtask

  task automatic t_reset;
    chk(carry == 1'b0, "R1 reset carry", int'(carry), 0);
    rst_n = 1'b1;
    en = 1'b1; mod8 = 1'b1; num = 3'd3;
    @(negedge clk);
    @(negedge clk);
    pattern("R1/R8 mod8 num3", 8, 8'b1010_0100);
  endtask

  task automatic t_mod8;
    int cnt;
    mod8 = 1'b1;
    for (int k = 1; k < 8; k++) begin
      num = 3'(k);
      clear_acc();
      count_run(16, cnt);
      chk(cnt == 2*k, "R3 mod8 count", cnt, 2*k);
    end
  endtask

  task automatic t_mod5;
    int cnt;
    mod8 = 1'b0; num = 3'd2;
    @(negedge clk);
    clear_acc();
    pattern("R8 mod5 num2", 5, 8'b0001_0100);
    for (int k = 1; k < 5; k++) begin
      num = 3'(k);
      clear_acc();
      count_run(10, cnt);
      chk(cnt == 2*k, "R4 mod5 count", cnt, 2*k);
    end
  endtask

  task automatic t_clamp;
    int cnt;
    mod8 = 1'b0;
    for (int k = 5; k < 8; k++) begin
      num = 3'(k);
      clear_acc();
      count_run(10, cnt);
      chk(cnt == 8, "R5 clamp", cnt, 8);
    end
  endtask

  task automatic preload6;
    int cnt;
    mod8 = 1'b1; num = 3'd3;
    @(negedge clk);
    clear_acc();
    count_run(2, cnt);
  endtask

  task automatic t_enable;
    int cnt;
    preload6();
    en = 1'b0;
    count_run(3, cnt);
    chk(cnt == 0, "R6 disabled carry", cnt, 0);
    en = 1'b1;
    pattern("R6 restart", 3, 8'b0000_0100);
  endtask

  task automatic t_zero;
    int cnt;
    preload6();
    num = 3'd0;
    count_run(4, cnt);
    chk(cnt == 0, "R7 zero num carry", cnt, 0);
    num = 3'd3;
    pattern("R7 restart", 3, 8'b0000_0100);
  endtask

  task automatic t_mode;
    preload6();
    mod8 = 1'b0;
    @(negedge clk);
    chk(carry == 1'b0, "R9 switch carry", int'(carry), 0);
    pattern("R9 mod5 num3 fresh", 5, 8'b0001_1010);
  endtask

  task automatic t_idle;
    int cnt;
    mod8 = 1'b1; num = 3'd7;
    clear_acc();
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cnt += int'(carry);
    end
    chk(cnt == 0, "R2 no strobe", cnt, 0);
  endtask

  initial begin
    #(CLK_P * 60000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_mod8();
    t_mod5();
    t_clamp();
    t_enable();
    t_zero();
    t_mode();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule